// File: doc/BRIEF.md
# Pipeline Stage Skid-Buffer Controller

This block is one stage of an in-order instruction pipeline. It sits between an upstream producer that delivers up to `IN_W` tokens per cycle and a downstream consumer that accepts up to `OUT_W` tokens per cycle. Tokens are opaque payloads. Each one carries a valid bit and a squashed bit. A squashed token is thrown away and never uses an output slot.

Three downstream sources can hold the stage through set and clear pulses. The stage keeps a sticky flag for each source. While the stage is held, or when more tokens arrive than the output can take, the tokens go into a skid buffer. The buffer holds `(DLY + 1) * IN_W` entries, where `DLY` is the upstream-to-stage latency. The stage then asks upstream to stop with a one-cycle block pulse. Once the hold is gone, the stage empties the skid buffer before it takes fresh input again, and it signals upstream to resume with a one-cycle unblock pulse.

A squash input flushes all state. A squash-in-progress input keeps the stage quiet until the flush has finished. All outputs are registered, so the result of a cycle's inputs appears after the next rising clock edge.

Top module: `skid_stage`

## Requirements
- R1: Reset behaviour:
  - After reset, all outputs are 0 and all stall flags are clear.
  - The stage is in its idle/pass-through mode with an empty skid buffer.
- R2: Stall flags:
  - Stall source i (bit 0 rename, bit 1 execute, bit 2 commit) has a sticky flag. A pulse on `stall_set_i[i]` sets it and a pulse on `stall_clr_i[i]` clears it.
  - If both pulses arrive in the same cycle, the clear wins.
  - The stage is held whenever any flag is set after that cycle's update.
- R3: Each cycle is resolved in this priority order:
  1. squash
  2. squash-in-progress
  3. stall
  4. leaving the blocked state
  5. leaving the squashing state
- R4: Pass-through when running or idle:
  - Non-squashed valid input tokens go straight to the output, up to `OUT_W` of them, on the cycle after they arrive.
  - They keep input order and are packed from slot 0 upward.
  - Squashed tokens use no slot.
- R5: If more than `OUT_W` tokens arrive while running:
  - The first `OUT_W` are sent.
  - The rest go into the skid buffer.
  - A block pulse is raised and the stage enters the blocked state.
- R6: While held:
  - Incoming tokens are appended to the skid buffer and no token is output.
  - The block pulse is raised only when the stage was not already blocked.
- R7: Unblocking:
  - Once no hold remains, a non-empty skid buffer drains at up to `OUT_W` tokens per cycle, oldest first.
  - Newly arriving tokens are appended behind the stored ones.
  - The cycle the buffer becomes empty raises an unblock pulse and returns the stage to running.
- R8: Squash:
  - A squash empties the skid buffer and drops the cycle's input.
  - It raises an unblock pulse only if the stage was blocked or unblocking.
  - The stage enters squashing, produces no output that cycle, and resumes running on the next cycle free of squash and stall.
- R9: Squash-in-progress: while asserted, without a squash, the stage stays in squashing, drops input, and raises no output and no pulse.
- R10: Cancelled handshake:
  - This case covers a stage that is blocked with an empty skid buffer, whose hold lifts while more than `OUT_W` tokens arrive.
  - The unblock it would raise is cancelled, and no block pulse is raised either.
  - The leftovers are stored and drained next cycle with an unblock pulse.
- R11: Overflow:
  - A push that would exceed skid capacity sets a sticky `overflow_o`, which clears only on reset.
  - The excess tokens are dropped and the stored ones are kept.
- R12: The skid buffer holds exactly `(DLY + 1) * IN_W` tokens without overflow.
- R13: Output framing:
  - The output valid mask is always contiguous from slot 0.
  - Block and unblock are never asserted together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_vld_i | input | IN_W | Per-slot valid of incoming tokens |
| in_sqd_i | input | IN_W | Per-slot squashed mark of incoming tokens |
| in_data_i | input | IN_W*PW | Incoming token payloads, slot 0 in the low bits |
| stall_set_i | input | 3 | Stall set pulses: bit 0 rename, bit 1 execute, bit 2 commit |
| stall_clr_i | input | 3 | Stall clear pulses, same bit order |
| squash_i | input | 1 | Flush request |
| squash_busy_i | input | 1 | Flush still in progress |
| out_vld_o | output | OUT_W | Per-slot valid of forwarded tokens |
| out_data_o | output | OUT_W*PW | Forwarded payloads, slot 0 in the low bits |
| block_o | output | 1 | One-cycle request for upstream to stop |
| unblock_o | output | 1 | One-cycle request for upstream to resume |
| overflow_o | output | 1 | Sticky skid-buffer overflow flag |

## Verification
The checker watches several properties on every cycle:
- The valid mask stays packed from slot 0.
- Block and unblock pulses never overlap, and two block pulses never come back to back.
- A squash or a squash-in-progress is followed by a silent cycle.
- A set-only stall pulse yields no output.
- The overflow flag stays sticky.

Other behaviours need the bench's scenario sequences:
- the ordering of drained skid entries against fresh input;
- the cancelled handshake when a blocked stage with an empty buffer receives too many tokens;
- the exact capacity limit;
- the conditional unblock on squash.

The bench also sweeps all 64 valid/squashed patterns of a three-slot input to cover packing.

// File: rtl/skid_pkg.sv
package skid_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RUN  = 3'd1,
    ST_BLK  = 3'd2,
    ST_UNB  = 3'd3,
    ST_SQ   = 3'd4
  } stage_st_e;

  localparam int unsigned NUM_STALL_SRC = 3;
endpackage

// File: rtl/skid_compact.sv
// Packs kept (valid and not squashed) tokens toward slot 0, order preserved.
module skid_compact #(
  parameter int IN_W = 3,
  parameter int PW   = 8,
  localparam int ICW = $clog2(IN_W + 1)
) (
  input  logic [IN_W-1:0]    vld_i,
  input  logic [IN_W-1:0]    sqd_i,
  input  logic [IN_W*PW-1:0] data_i,
  output logic [IN_W*PW-1:0] data_o,
  output logic [ICW-1:0]     cnt_o
);
  always_comb begin
    int k;
    k = 0;
    data_o = '0;
    for (int i = 0; i < IN_W; i++) begin
      if (vld_i[i] && !sqd_i[i]) begin
        data_o[k*PW +: PW] = data_i[i*PW +: PW];
        k = k + 1;
      end
    end
    cnt_o = ICW'(k);
  end
endmodule

// File: rtl/skid_stall_flags.sv
// Sticky per-source hold flags; clear beats set in the same cycle.
module skid_stall_flags #(
  parameter int NSRC = skid_pkg::NUM_STALL_SRC
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] set_i,
  input  logic [NSRC-1:0] clr_i,
  output logic            stalled_o
);
  logic [NSRC-1:0] flag_q, flag_d;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign flag_d[g] = (flag_q[g] | set_i[g]) & ~clr_i[g];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flag_q[g] <= 1'b0;
      else         flag_q[g] <= flag_d[g];
    end
  end

  assign stalled_o = |flag_d;
endmodule

// File: rtl/skid_store.sv
// Shifting skid buffer: entry 0 is always the oldest.
module skid_store #(
  parameter int DEPTH = 6,
  parameter int IN_W  = 3,
  parameter int OUT_W = 2,
  parameter int PW    = 8,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int ICW  = $clog2(IN_W + 1),
  localparam int OCW  = $clog2(OUT_W + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clr_i,
  input  logic [OCW-1:0]      pop_i,
  input  logic [ICW-1:0]      push_i,
  input  logic [IN_W*PW-1:0]  push_data_i,
  output logic [CW-1:0]       cnt_o,
  output logic [OUT_W*PW-1:0] head_o,
  output logic                ovf_o
);
  logic [DEPTH*PW-1:0] mem_q, mem_d;
  logic [CW-1:0]       cnt_q, cnt_d;

  always_comb begin
    int keep, tot;
    keep  = int'(cnt_q) - int'(pop_i);
    tot   = keep + int'(push_i);
    mem_d = mem_q;
    for (int i = 0; i < DEPTH; i++) begin
      if (i + int'(pop_i) < int'(cnt_q)) begin
        mem_d[i*PW +: PW] = mem_q[(i + int'(pop_i))*PW +: PW];
      end else if (i - keep < int'(push_i)) begin
        mem_d[i*PW +: PW] = push_data_i[(i - keep)*PW +: PW];
      end
    end
    ovf_o = (tot > DEPTH);
    cnt_d = ovf_o ? CW'(DEPTH) : CW'(tot);
    if (clr_i) begin
      ovf_o = 1'b0;
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q <= '0;
      cnt_q <= '0;
    end else begin
      mem_q <= mem_d;
      cnt_q <= cnt_d;
    end
  end

  for (genvar k = 0; k < OUT_W; k++) begin : g_head
    if (k < DEPTH) begin : g_in
      assign head_o[k*PW +: PW] = mem_q[k*PW +: PW];
    end else begin : g_out
      assign head_o[k*PW +: PW] = '0;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/skid_stage.sv
module skid_stage
  import skid_pkg::*;
#(
  parameter int IN_W  = 3,
  parameter int OUT_W = 2,
  parameter int PW    = 8,
  parameter int DLY   = 1,
  localparam int DEPTH = (DLY + 1) * IN_W,
  localparam int CW    = $clog2(DEPTH + 1),
  localparam int ICW   = $clog2(IN_W + 1),
  localparam int OCW   = $clog2(OUT_W + 1),
  localparam int NSRC  = NUM_STALL_SRC
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [IN_W-1:0]     in_vld_i,
  input  logic [IN_W-1:0]     in_sqd_i,
  input  logic [IN_W*PW-1:0]  in_data_i,
  input  logic [NSRC-1:0]     stall_set_i,
  input  logic [NSRC-1:0]     stall_clr_i,
  input  logic                squash_i,
  input  logic                squash_busy_i,
  output logic [OUT_W-1:0]    out_vld_o,
  output logic [OUT_W*PW-1:0] out_data_o,
  output logic                block_o,
  output logic                unblock_o,
  output logic                overflow_o
);
  stage_st_e st_q, st_d;

  logic [IN_W*PW-1:0]  inc_data;
  logic [ICW-1:0]      inc_n;
  logic                stalled;
  logic [CW-1:0]       sk_cnt;
  logic [OUT_W*PW-1:0] sk_head;
  logic                sk_clr, sk_ovf;
  logic [OCW-1:0]      pop_n;
  logic [ICW-1:0]      push_n;
  logic [IN_W*PW-1:0]  push_data;
  logic [OUT_W-1:0]    vld_d;
  logic [OUT_W*PW-1:0] dat_d;
  logic                blk_d, unblk_d;

  skid_compact #(.IN_W(IN_W), .PW(PW)) u_compact (
    .vld_i  (in_vld_i),
    .sqd_i  (in_sqd_i),
    .data_i (in_data_i),
    .data_o (inc_data),
    .cnt_o  (inc_n)
  );

  skid_stall_flags #(.NSRC(NSRC)) u_flags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (stall_set_i),
    .clr_i     (stall_clr_i),
    .stalled_o (stalled)
  );

  skid_store #(.DEPTH(DEPTH), .IN_W(IN_W), .OUT_W(OUT_W), .PW(PW)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (sk_clr),
    .pop_i       (pop_n),
    .push_i      (push_n),
    .push_data_i (push_data),
    .cnt_o       (sk_cnt),
    .head_o      (sk_head),
    .ovf_o       (sk_ovf)
  );

  always_comb begin
    stage_st_e st_w;
    int take, spare;
    st_d      = st_q;
    sk_clr    = 1'b0;
    pop_n     = '0;
    push_n    = '0;
    push_data = inc_data;
    vld_d     = '0;
    dat_d     = '0;
    blk_d     = 1'b0;
    unblk_d   = 1'b0;
    take      = 0;
    spare     = 0;
    st_w      = st_q;
    if (squash_i) begin
      sk_clr  = 1'b1;
      unblk_d = (st_q == ST_BLK) || (st_q == ST_UNB);
      st_d    = ST_SQ;
    end else if (squash_busy_i) begin
      st_d = ST_SQ;
    end else if (stalled) begin
      push_n = inc_n;
      blk_d  = (st_q != ST_BLK);
      st_d   = ST_BLK;
    end else begin
      if (st_q == ST_BLK) begin
        if (sk_cnt == '0) begin
          unblk_d = 1'b1;
          st_w    = ST_RUN;
        end else begin
          st_w = ST_UNB;
        end
      end else if (st_q == ST_SQ) begin
        st_w = ST_RUN;
      end
      st_d = st_w;
      if (st_w == ST_UNB) begin
        // drain oldest first, park fresh arrivals behind
        take  = (int'(sk_cnt) < OUT_W) ? int'(sk_cnt) : OUT_W;
        pop_n = OCW'(take);
        for (int k = 0; k < OUT_W; k++) begin
          if (k < take) begin
            vld_d[k]            = 1'b1;
            dat_d[k*PW +: PW]   = sk_head[k*PW +: PW];
          end
        end
        push_n = inc_n;
        if (int'(sk_cnt) - take + int'(inc_n) == 0) begin
          unblk_d = 1'b1;
          st_d    = ST_RUN;
        end
      end else begin
        take = (int'(inc_n) < OUT_W) ? int'(inc_n) : OUT_W;
        for (int k = 0; k < OUT_W; k++) begin
          if (k < take) begin
            vld_d[k]          = 1'b1;
            dat_d[k*PW +: PW] = inc_data[k*PW +: PW];
          end
        end
        spare = int'(inc_n) - take;
        if (spare > 0) begin
          push_n    = ICW'(spare);
          push_data = inc_data >> (OUT_W * PW);
          // a resume raised this cycle is cancelled rather than followed by a block
          if (unblk_d) unblk_d = 1'b0;
          else         blk_d   = 1'b1;
          st_d = ST_BLK;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      out_vld_o  <= '0;
      out_data_o <= '0;
      block_o    <= 1'b0;
      unblock_o  <= 1'b0;
      overflow_o <= 1'b0;
    end else begin
      st_q       <= st_d;
      out_vld_o  <= vld_d;
      out_data_o <= dat_d;
      block_o    <= blk_d;
      unblock_o  <= unblk_d;
      overflow_o <= overflow_o | sk_ovf;
    end
  end
endmodule

// File: rtl/skid_stage_chk.sv
module skid_stage_chk #(
  parameter int OUT_W = 2,
  parameter int NSRC  = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [NSRC-1:0]  stall_set_i,
  input logic [NSRC-1:0]  stall_clr_i,
  input logic             squash_i,
  input logic             squash_busy_i,
  input logic [OUT_W-1:0] out_vld_o,
  input logic             block_o,
  input logic             unblock_o,
  input logic             overflow_o
);
  a_r13_packed_slots: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_vld_o & (out_vld_o + OUT_W'(1))) == '0);

  a_r13_pulses_apart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(block_o && unblock_o));

  a_r6_single_block: assert property (@(posedge clk_i) disable iff (!rst_ni)
    block_o |=> !block_o);

  a_r8_squash_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    squash_i |=> (out_vld_o == '0) && !block_o);

  a_r9_busy_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (squash_busy_i && !squash_i) |=> (out_vld_o == '0) && !block_o && !unblock_o);

  a_r2_hold_no_output: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|(stall_set_i & ~stall_clr_i)) && !squash_i && !squash_busy_i)
      |=> (out_vld_o == '0) && !unblock_o);

  a_r11_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |=> overflow_o);
endmodule

bind skid_stage skid_stage_chk #(.OUT_W(OUT_W), .NSRC(NSRC)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .stall_set_i   (stall_set_i),
  .stall_clr_i   (stall_clr_i),
  .squash_i      (squash_i),
  .squash_busy_i (squash_busy_i),
  .out_vld_o     (out_vld_o),
  .block_o       (block_o),
  .unblock_o     (unblock_o),
  .overflow_o    (overflow_o)
);

// File: tb/sim_skid_stage.sv
`timescale 1ns/1ps
module sim_skid_stage;
  localparam int IN_W  = 3;
  localparam int OUT_W = 2;
  localparam int PW    = 8;
  localparam int DLY   = 1;

  logic clk = 1'b0;
  logic rst_n;
  logic [IN_W-1:0]     in_vld, in_sqd;
  logic [IN_W*PW-1:0]  in_data;
  logic [2:0]          st_set, st_clr;
  logic                sq, busy;
  logic [OUT_W-1:0]    out_vld;
  logic [OUT_W*PW-1:0] out_data;
  logic                blk, unblk, ovf;

  always #5 clk = ~clk;

  skid_stage #(.IN_W(IN_W), .OUT_W(OUT_W), .PW(PW), .DLY(DLY)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .in_vld_i(in_vld), .in_sqd_i(in_sqd), .in_data_i(in_data),
    .stall_set_i(st_set), .stall_clr_i(st_clr),
    .squash_i(sq), .squash_busy_i(busy),
    .out_vld_o(out_vld), .out_data_o(out_data),
    .block_o(blk), .unblock_o(unblk), .overflow_o(ovf)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] slot(input int k);
    return out_data[k*PW +: PW];
  endfunction

  task automatic idle_in();
    in_vld = '0; in_sqd = '0; in_data = '0;
    st_set = '0; st_clr = '0; sq = 1'b0; busy = 1'b0;
  endtask

  task automatic toks(input logic [2:0] v, input logic [7:0] d0, input logic [7:0] d1,
                      input logic [7:0] d2);
    in_vld = v; in_sqd = '0; in_data = {d2, d1, d0};
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [2:0] v, s;
    logic [7:0] e [3];
    int n;
    rst_n = 1'b0;
    idle_in();
    cyc(); cyc();
    chk("R1 reset vld", out_vld, 0);
    chk("R1 reset pulses", {blk, unblk, ovf}, 0);
    rst_n = 1'b1;
    cyc();

    // sweep every valid/squashed pattern from idle
    for (int p = 0; p < 64; p++) begin
      v = p[2:0];
      s = p[5:3];
      n = 0;
      for (int i = 0; i < 3; i++) begin
        in_data[i*PW +: PW] = 8'(p * 4 + i);
        if (v[i] && !s[i]) begin
          e[n] = 8'(p * 4 + i);
          n++;
        end
      end
      in_vld = v; in_sqd = s;
      cyc();
      idle_in();
      if (n <= 2) begin
        chk("R4 mask", out_vld, (1 << n) - 1);
        for (int k = 0; k < n; k++) chk("R4 data", slot(k), e[k]);
        chk("R4 no block", blk, 0);
        cyc();
        chk("R4 idle", out_vld, 0);
      end else begin
        chk("R5 mask", out_vld, 3);
        chk("R5 slot0", slot(0), e[0]);
        chk("R5 slot1", slot(1), e[1]);
        chk("R5 block", blk, 1);
        cyc();
        chk("R7 drain mask", out_vld, 1);
        chk("R7 drain data", slot(0), e[2]);
        chk("R7 unblock", unblk, 1);
        chk("R6 block once", blk, 0);
        cyc();
        chk("R7 settled", {blk, unblk, out_vld}, 0);
      end
    end

    // hold, clear-wins, drain order
    st_set = 3'b010; toks(3'b011, 8'hA0, 8'hA1, 8'h00);
    cyc(); idle_in();
    chk("R6 held vld", out_vld, 0);
    chk("R6 block pulse", blk, 1);
    toks(3'b001, 8'hA2, 8'h00, 8'h00);
    cyc(); idle_in();
    chk("R6 held again", out_vld, 0);
    chk("R6 no second block", blk, 0);
    st_set = 3'b100; st_clr = 3'b110;
    cyc(); idle_in();
    chk("R2 clear wins", out_vld, 3);
    chk("R7 oldest0", slot(0), 8'hA0);
    chk("R7 oldest1", slot(1), 8'hA1);
    chk("R7 no unblock yet", {blk, unblk}, 0);
    toks(3'b001, 8'hA3, 8'h00, 8'h00);
    cyc(); idle_in();
    chk("R7 skid before fresh", {out_vld, slot(0)}, {2'b01, 8'hA2});
    chk("R7 still unblocking", unblk, 0);
    cyc();
    chk("R7 appended", {out_vld, slot(0)}, {2'b01, 8'hA3});
    chk("R7 unblock pulse", unblk, 1);
    toks(3'b001, 8'hA4, 8'h00, 8'h00);
    cyc(); idle_in();
    chk("R7 running again", {out_vld, slot(0)}, {2'b01, 8'hA4});

    // priority and squash
    st_set = 3'b001; toks(3'b111, 8'hB0, 8'hB1, 8'hB2);
    cyc(); idle_in();
    chk("R6 block", blk, 1);
    sq = 1'b1; st_set = 3'b010; toks(3'b111, 8'hB3, 8'hB4, 8'hB5);
    cyc(); idle_in();
    chk("R3 squash over stall", {blk, out_vld}, 0);
    chk("R8 unblock on squash", unblk, 1);
    busy = 1'b1; toks(3'b011, 8'hB5, 8'hB6, 8'h00);
    cyc(); idle_in();
    chk("R9 busy silent", {blk, unblk, out_vld}, 0);
    st_clr = 3'b011; toks(3'b001, 8'hB7, 8'h00, 8'h00);
    cyc(); idle_in();
    chk("R8 resume", {out_vld, slot(0)}, {2'b01, 8'hB7});
    cyc();
    chk("R8 skid flushed", {blk, unblk, out_vld}, 0);
    sq = 1'b1;
    cyc(); idle_in();
    chk("R8 no unblock when running", {blk, unblk, out_vld}, 0);
    cyc();

    // cancelled handshake
    st_set = 3'b100;
    cyc(); idle_in();
    chk("R10 block", blk, 1);
    st_clr = 3'b100; toks(3'b111, 8'hC0, 8'hC1, 8'hC2);
    cyc(); idle_in();
    chk("R10 out", {out_vld, slot(1), slot(0)}, {2'b11, 8'hC1, 8'hC0});
    chk("R10 no pulses", {blk, unblk}, 0);
    cyc();
    chk("R10 drain", {out_vld, slot(0)}, {2'b01, 8'hC2});
    chk("R10 late unblock", unblk, 1);
    cyc();

    // capacity and overflow
    st_set = 3'b001; toks(3'b111, 8'hD0, 8'hD1, 8'hD2);
    cyc(); idle_in();
    toks(3'b111, 8'hD3, 8'hD4, 8'hD5);
    cyc(); idle_in();
    chk("R12 full no overflow", ovf, 0);
    toks(3'b111, 8'hD6, 8'hD7, 8'hD8);
    cyc(); idle_in();
    chk("R11 overflow", ovf, 1);
    st_clr = 3'b001;
    cyc(); idle_in();
    chk("R11 kept0", {out_vld, slot(1), slot(0)}, {2'b11, 8'hD1, 8'hD0});
    cyc();
    chk("R11 kept1", {out_vld, slot(1), slot(0)}, {2'b11, 8'hD3, 8'hD2});
    cyc();
    chk("R12 kept2", {out_vld, slot(1), slot(0)}, {2'b11, 8'hD5, 8'hD4});
    chk("R12 unblock", unblk, 1);
    chk("R11 sticky", ovf, 1);
    cyc();
    chk("R11 excess dropped", out_vld, 0);

    rst_n = 1'b0;
    cyc();
    chk("R1 reset clears", {ovf, blk, unblk, out_vld}, 0);
    rst_n = 1'b1;
    toks(3'b100, 8'h00, 8'h00, 8'hE0);
    cyc(); idle_in();
    chk("R1 pass after reset", {out_vld, slot(0)}, {2'b01, 8'hE0});

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule